// File: doc/BRIEF.md
# Dual-Channel Configurable CRC Unit

This block keeps two checksum registers side by side, one per redundant communication channel, and advances each by a full 16-bit data word in a single clock. Each channel runs one of two generator polynomials. The narrow mode uses the 16-bit polynomial 0x1021. The wide mode uses the 24-bit polynomial 0x5D6DCB. Both shift most-significant bit first with no bit reflection. The two channels share nothing but the clock and reset, so firmware can hash both channel streams in the same cycle, each in its own mode.

Firmware drives the block through plain level controls. A start pulse loads a channel with a seed. A word strobe absorbs the word on the internal bus. The checksum is always visible at the outputs. A compare strobe with an expected value raises a match flag. Words can arrive on consecutive cycles, so the contents of an instruction memory can be streamed straight through with ordinary moves as a firmware self-test. The mode of a channel may only be changed in the window between a start and the first absorbed word. A change at any other time is refused and flagged.

Top module: `dual_crc_engine`

## Requirements
- R1: After reset every channel holds a checksum of zero, is in narrow (16-bit) mode with `ch_wide` low, has `ch_mode_err` low, and accepts a mode change as if just started.
- R2: A start pulse (`ch_init`) loads the checksum with `ch_seed`. In narrow mode (`ch_wide_sel`=0) it loads only `ch_seed[15:0]` and bits 23:16 become zero; in wide mode (`ch_wide_sel`=1) it loads all 24 bits. The mode is taken from `ch_wide_sel` in the same cycle. A start overrides a word strobe in the same cycle.
- R3: In narrow mode a word strobe replaces the checksum, in the next cycle, with the polynomial-0x1021 update over all 16 word bits, bit 15 first. For each bit, feedback = checksum bit 15 XOR data bit, the register shifts left by one, and it is XORed with 0x1021 when feedback is 1. Checksum bits 23:16 stay zero in this mode.
- R4: In wide mode the same update uses checksum bit 23 as the feedback source and the polynomial 0x5D6DCB.
- R5: The two channels are independent. Activity on one never alters the checksum, mode or error flag of the other, and both may update in the same cycle in different modes.
- R6: A word strobe held high for consecutive cycles absorbs one new word every cycle, with no lost or repeated word.
- R7: With no start, no word strobe and no mode request, the checksum holds its value.
- R8: A mode request (`ch_wide_sel` differing from `ch_wide`) is accepted when no word has been absorbed since the last start or reset and no word strobe is present in that cycle. When accepted, the mode flips in the next cycle and the checksum keeps its low 16 bits, with bits 23:16 zero.
- R9: Any other mode request leaves the mode unchanged and sets `ch_mode_err`. The flag stays set until the next start.
- R10: `ch_match` is high exactly when `ch_check` is high and the checksum equals `ch_expect` restricted to the active width. In narrow mode, `ch_expect[23:16]` is ignored.
- R11: A start clears `ch_mode_err` and opens the mode-change window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_init | input | CHANNELS | Start pulse per channel |
| ch_seed | input | CHANNELS x 24 | Seed loaded on start |
| ch_wide_sel | input | CHANNELS | Requested mode, 1 = 24-bit polynomial |
| ch_feed | input | CHANNELS | Word strobe per channel |
| ch_word | input | CHANNELS x 16 | Data word from the internal bus |
| ch_check | input | CHANNELS | Compare strobe |
| ch_expect | input | CHANNELS x 24 | Expected checksum for the compare |
| ch_crc | output | CHANNELS x 24 | Current checksum |
| ch_wide | output | CHANNELS | Active mode, 1 = 24-bit |
| ch_match | output | CHANNELS | Compare result |
| ch_mode_err | output | CHANNELS | Sticky refused-mode-change flag |

## Verification
The update is first tried with the single word 0x0001 on a zero checksum. The result must equal the bare polynomial in each mode, which separates a wrong polynomial or a wrong feedback tap from a wrong shift order. An irregular burst of back-to-back words on one channel, run against a bitwise reference model, exposes lost, repeated or bit-reversed words. The idle channel alongside shows any cross-talk. Start, word strobe and mode request are then applied in every combination of timing to tell a start that loses priority, a mode window that stays open too long, and a flag that is not sticky. Compares with junk in the upper expected bits check that narrow mode masks them off.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CRC_W    = 24;
    localparam int NARROW_W = 16;
    localparam int DATA_W   = 16;

    localparam logic [CRC_W-1:0] POLY_NARROW = 24'h001021;
    localparam logic [CRC_W-1:0] POLY_WIDE   = 24'h5D6DCB;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             wide;
        logic             armed;
        logic             err;
    } chan_state_t;

    function automatic logic [CRC_W-1:0] width_mask(input logic wide);
        return wide ? {CRC_W{1'b1}}
                    : {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

    // One word, MSB first, no reflection; fully unrolled by the loop.
    function automatic logic [CRC_W-1:0] advance(
        input logic [CRC_W-1:0]  c_in,
        input logic [DATA_W-1:0] word,
        input int                w,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] c;
        logic [CRC_W-1:0] m;
        logic             fb;
        m = {CRC_W{1'b1}} >> (CRC_W - w);
        c = c_in & m;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[w-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
            c = c & m;
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_step.sv
module crc_step
    import crc_pkg::*;
#(
    parameter int               STEP_DATA_W = crc_pkg::DATA_W,
    parameter logic [CRC_W-1:0] P_NARROW    = crc_pkg::POLY_NARROW,
    parameter logic [CRC_W-1:0] P_WIDE      = crc_pkg::POLY_WIDE
) (
    input  logic [CRC_W-1:0]       crc_in,
    input  logic [STEP_DATA_W-1:0] word,
    input  logic                   wide,
    output logic [CRC_W-1:0]       crc_out
);

    localparam int N_VARIANTS = 2;

    logic [N_VARIANTS-1:0][CRC_W-1:0] variant_res;

    for (genvar v = 0; v < N_VARIANTS; v++) begin : g_variant
        localparam int               VW    = (v == 1) ? CRC_W : NARROW_W;
        localparam logic [CRC_W-1:0] VPOLY = (v == 1) ? P_WIDE : P_NARROW;
        always_comb begin
            variant_res[v] = advance(crc_in, word, VW, VPOLY);
        end
    end

    assign crc_out = variant_res[wide];

endmodule

// File: rtl/crc_channel.sv
module crc_channel
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [CRC_W-1:0]  seed,
    input  logic              wide_sel,
    input  logic              feed,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  crc,
    output logic              wide,
    output logic              mode_err
);

    chan_state_t      state_d, state_q;
    logic [CRC_W-1:0] stepped;

    crc_step u_step (
        .crc_in  (state_q.crc),
        .word    (word),
        .wide    (state_q.wide),
        .crc_out (stepped)
    );

    always_comb begin
        state_d = state_q;
        if (init) begin
            state_d.crc   = seed & width_mask(wide_sel);
            state_d.wide  = wide_sel;
            state_d.armed = 1'b1;
            state_d.err   = 1'b0;
        end else begin
            if (wide_sel != state_q.wide) begin
                if (state_q.armed && !feed) begin
                    state_d.wide = wide_sel;
                    state_d.crc  = state_q.crc & width_mask(1'b0);
                end else begin
                    state_d.err = 1'b1;
                end
            end
            if (feed) begin
                state_d.crc   = stepped;
                state_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.crc   <= '0;
            state_q.wide  <= 1'b0;
            state_q.armed <= 1'b1;
            state_q.err   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign crc      = state_q.crc;
    assign wide     = state_q.wide;
    assign mode_err = state_q.err;

    p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> crc == $past(seed & width_mask(wide_sel)));

    p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> crc[CRC_W-1:NARROW_W] == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !feed && wide_sel == wide) |=> $stable(crc));

    p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !state_q.armed && wide_sel != wide) |=> mode_err && $stable(wide));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && !init) |=> mode_err);

    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !mode_err && state_q.armed);

endmodule

// File: rtl/crc_compare.sv
module crc_compare
    import crc_pkg::*;
(
    input  logic             check,
    input  logic             wide,
    input  logic [CRC_W-1:0] crc,
    input  logic [CRC_W-1:0] expect_val,
    output logic             match
);

    always_comb begin
        match = check && (crc == (expect_val & width_mask(wide)));
    end

endmodule

// File: rtl/dual_crc_engine.sv
module dual_crc_engine
    import crc_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CHANNELS-1:0]              ch_init,
    input  logic [CHANNELS-1:0][CRC_W-1:0]   ch_seed,
    input  logic [CHANNELS-1:0]              ch_wide_sel,
    input  logic [CHANNELS-1:0]              ch_feed,
    input  logic [CHANNELS-1:0][DATA_W-1:0]  ch_word,
    input  logic [CHANNELS-1:0]              ch_check,
    input  logic [CHANNELS-1:0][CRC_W-1:0]   ch_expect,
    output logic [CHANNELS-1:0][CRC_W-1:0]   ch_crc,
    output logic [CHANNELS-1:0]              ch_wide,
    output logic [CHANNELS-1:0]              ch_match,
    output logic [CHANNELS-1:0]              ch_mode_err
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        crc_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (ch_init[c]),
            .seed     (ch_seed[c]),
            .wide_sel (ch_wide_sel[c]),
            .feed     (ch_feed[c]),
            .word     (ch_word[c]),
            .crc      (ch_crc[c]),
            .wide     (ch_wide[c]),
            .mode_err (ch_mode_err[c])
        );

        crc_compare u_cmp (
            .check      (ch_check[c]),
            .wide       (ch_wide[c]),
            .crc        (ch_crc[c]),
            .expect_val (ch_expect[c]),
            .match      (ch_match[c])
        );

        p_match_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ch_match[c] |-> ch_check[c]);
    end

endmodule

// File: tb/dual_crc_engine_bench.sv
module dual_crc_engine_bench;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ch_init = '0;
    logic [1:0][23:0] ch_seed = '0;
    logic [1:0]       ch_wide_sel = '0;
    logic [1:0]       ch_feed = '0;
    logic [1:0][15:0] ch_word = '0;
    logic [1:0]       ch_check = '0;
    logic [1:0][23:0] ch_expect = '0;
    logic [1:0][23:0] ch_crc;
    logic [1:0]       ch_wide;
    logic [1:0]       ch_match;
    logic [1:0]       ch_mode_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dual_crc_engine u_dual_crc_engine (
        .clk, .rst_n, .ch_init, .ch_seed, .ch_wide_sel, .ch_feed, .ch_word,
        .ch_check, .ch_expect, .ch_crc, .ch_wide, .ch_match, .ch_mode_err
    );

    // Independent bitwise reference written from R3/R4.
    function automatic logic [23:0] ref_step(logic [23:0] c, logic [15:0] w, logic wide);
        int          top  = wide ? 23 : 15;
        logic [23:0] poly = wide ? 24'h5D6DCB : 24'h001021;
        logic [23:0] m    = wide ? 24'hFFFFFF : 24'h00FFFF;
        for (int i = 15; i >= 0; i--) begin
            logic fb = c[top] ^ w[i];
            c = (c << 1) & m;
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change 2 ns after a rising edge; outputs sampled at the same point.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic start(int c, logic wide, logic [23:0] seed);
        ch_init[c] = 1; ch_wide_sel[c] = wide; ch_seed[c] = seed;
        tick();
        ch_init[c] = 0;
    endtask

    task automatic t_reset();
        for (int c = 0; c < 2; c++) begin
            chk("R1 crc", ch_crc[c], 0);
            chk("R1 wide", ch_wide[c], 0);
            chk("R1 err", ch_mode_err[c], 0);
        end
        ch_check = 2'b11; ch_expect = '0; #1;
        chk("R10 reset match", ch_match, 2'b11);
        ch_check = 0;
        ch_wide_sel[1] = 1; tick();
        chk("R1 change window open", ch_wide[1], 1);
        chk("R1 no error", ch_mode_err[1], 0);
    endtask

    task automatic t_single_word();
        start(0, 0, 0); ch_init[1] = 1; ch_wide_sel[1] = 1; ch_seed[1] = 0; tick(); ch_init = 0;
        ch_feed = 2'b11; ch_word[0] = 16'h0001; ch_word[1] = 16'h0001;
        tick(); ch_feed = 0;
        chk("R3 narrow poly", ch_crc[0], 24'h001021);
        chk("R4 wide poly", ch_crc[1], 24'h5D6DCB);
        chk("R5 both modes concurrently", ch_wide, 2'b10);
    endtask

    task automatic t_stream();
        logic [23:0] exp0;
        logic [23:0] hold1;
        start(0, 0, 24'h00FFFF);
        exp0 = 24'h00FFFF; hold1 = ch_crc[1];
        for (int k = 0; k < 10; k++) begin
            logic [15:0] w = 16'hA5C3 ^ 16'(k * 16'h1357) ^ (16'h8000 >> k);
            ch_feed[0] = 1; ch_word[0] = w;
            exp0 = ref_step(exp0, w, 0);
            tick();
            chk("R6 stream word", ch_crc[0], exp0);
            chk("R5 idle channel stable", ch_crc[1], hold1);
        end
        chk("R3 upper bits zero", ch_crc[0][23:16], 0);
        ch_feed = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 hold", ch_crc[0], exp0);
        end
        // Wide stream on channel 1.
        start(1, 1, 24'h123456);
        exp0 = 24'h123456;
        for (int k = 0; k < 5; k++) begin
            logic [15:0] w = 16'(16'h0F0F * (k + 3));
            ch_feed[1] = 1; ch_word[1] = w;
            exp0 = ref_step(exp0, w, 1);
            tick();
            chk("R4 wide stream", ch_crc[1], exp0);
        end
        ch_feed = 0;
    endtask

    task automatic t_init_priority();
        ch_init[0] = 1; ch_wide_sel[0] = 0; ch_seed[0] = 24'hABCDEF;
        ch_feed[0] = 1; ch_word[0] = 16'hFFFF;
        tick(); ch_init = 0; ch_feed = 0;
        chk("R2 narrow seed masked, start wins", ch_crc[0], 24'h00CDEF);
        start(0, 1, 24'hABCDEF);
        chk("R2 wide seed", ch_crc[0], 24'hABCDEF);
        chk("R2 mode taken", ch_wide[0], 1);
    endtask

    task automatic t_mode_ok();
        logic [23:0] e;
        start(0, 0, 24'h123456);
        ch_wide_sel[0] = 1; tick();
        chk("R8 accepted", ch_wide[0], 1);
        chk("R8 low bits kept", ch_crc[0], 24'h003456);
        chk("R8 no error", ch_mode_err[0], 0);
        ch_feed[0] = 1; ch_word[0] = 16'hBEEF; tick(); ch_feed = 0;
        e = ref_step(24'h003456, 16'hBEEF, 1);
        chk("R8 wide after change", ch_crc[0], e);
    endtask

    task automatic t_mode_bad();
        logic [23:0] e;
        e = ch_crc[0];
        ch_wide_sel[0] = 0; tick();
        chk("R9 refused", ch_wide[0], 1);
        chk("R9 flagged", ch_mode_err[0], 1);
        chk("R9 crc untouched", ch_crc[0], e);
        ch_wide_sel[0] = 1; tick(); tick();
        chk("R9 sticky", ch_mode_err[0], 1);
        chk("R5 other channel clean", ch_mode_err[1], 0);
        start(0, 1, 24'h000777);
        chk("R11 cleared", ch_mode_err[0], 0);
        chk("R11 seed", ch_crc[0], 24'h000777);
        // Request in the window but together with a word: refused.
        ch_wide_sel[0] = 0; ch_feed[0] = 1; ch_word[0] = 16'h1234; tick(); ch_feed = 0;
        chk("R9 with word", ch_mode_err[0], 1);
        chk("R9 mode kept", ch_wide[0], 1);
        chk("R9 word absorbed", ch_crc[0], ref_step(24'h000777, 16'h1234, 1));
        start(0, 1, 0);
        ch_wide_sel[0] = 0; tick();
        chk("R11 window reopened", ch_wide[0], 0);
        chk("R11 no error", ch_mode_err[0], 0);
    endtask

    task automatic t_match();
        logic [23:0] e;
        start(0, 0, 24'h00BEEF);
        ch_feed[0] = 1; ch_word[0] = 16'h5A5A; tick(); ch_feed = 0;
        e = ref_step(24'h00BEEF, 16'h5A5A, 0);
        ch_check[0] = 1; ch_expect[0] = e | 24'hC30000; #1;
        chk("R10 narrow ignores upper", ch_match[0], 1);
        ch_expect[0] = e ^ 24'h000001; #1;
        chk("R10 mismatch", ch_match[0], 0);
        ch_expect[0] = e; ch_check[0] = 0; #1;
        chk("R10 gated", ch_match[0], 0);
        ch_check[1] = 1; ch_expect[1] = ch_crc[1] ^ 24'h800000; #1;
        chk("R10 wide upper compared", ch_match[1], 0);
        ch_expect[1] = ch_crc[1]; #1;
        chk("R10 wide match", ch_match[1], 1);
        ch_check = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_single_word();
        t_stream();
        t_init_priority();
        t_mode_ok();
        t_mode_bad();
        t_match();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule